// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer arithmetic unit of a small 32-bit processor core, together with the flag state and the condition evaluator that sit beside it. It has two register operands and a 4-bit operation selector. It produces the sum, the difference, the bitwise AND or the bitwise XOR on the same cycle. When a valid integer operation commits, it stores three flags: zero, sign and signed overflow. No other instruction changes these flags.

A separate 4-bit condition selector is decoded against the stored flags into one "condition true" bit. The same evaluator serves the conditional jumps and the conditional register moves. A move with code 0 is a plain move, and a jump with code 0 is unconditional. A conditional move writes its destination only when this bit is high. That gating is done by the writeback logic outside the block.

The commit input is a plain valid strobe. The block never stalls and applies no back-pressure, so no ready signal exists. Every cycle on which `op_valid` is high with a legal selector is taken as a commit.

Top module: `alu_ccu`

## Requirements
- R1: With `op_func` = 0, `op_result` equals `op_a + op_b` modulo 2^32, combinationally, whatever the value of `op_valid`.
- R2: With `op_func` = 1, `op_result` equals `op_b - op_a` modulo 2^32.
- R3: With `op_func` = 2, `op_result` equals `op_a & op_b`. With `op_func` = 3, it equals `op_a ^ op_b`.
- R4: On a clock edge with `op_valid` high and `op_func` in 0..3, the flags take these values, visible the next cycle:
  - ZF is set when the result is zero.
  - SF is bit 31 of the result.
  - For add, OF is set when the operands share a sign and the result's sign differs from it.
  - For subtract, OF is set when the operand signs differ and the result's sign differs from that of `op_b`.
  - For AND and XOR, OF is 0.
- R5: The flags keep their value on any edge where `op_valid` is low, or where `op_func` is in 4..15.
- R6: While `rst_n` is low, and after reset until the first commit, ZF=1, SF=0 and OF=0.
- R7: `cond_true` follows the stored flags, with L = SF^OF, according to `cond_func`:
  - 0 always
  - 1 (le): L|ZF
  - 2 (l): L
  - 3 (e): ZF
  - 4 (ne): !ZF
  - 5 (ge): !L
  - 6 (g): !L & !ZF
- R8: For `cond_func` in 7..15, `cond_true` is 0.
- R9: For `op_func` in 4..15, `op_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flags |
| op_valid | input | 1 | An integer operation commits this cycle |
| op_func | input | 4 | Operation selector: 0 add, 1 sub, 2 and, 3 xor |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| op_result | output | 32 | Combinational result |
| cond_func | input | 4 | Condition selector for jumps and moves |
| cond_true | output | 1 | Selected condition holds on the stored flags |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| flag_of | output | 1 | Stored overflow flag |

## Verification
The hardest states to reach are the flag combinations that signed overflow creates. Two examples are SF=1 with OF=1, where "less" must be false even though the sign is negative, and a zero result produced by overflow. Random operands almost never hit these. The stimulus therefore pairs every operand from a set of corner values: zero, one, all ones, the largest positive value, the most negative value and its neighbour, and two alternating patterns. These pairs run under every operation selector and are mixed with pseudo-random pairs. After each commit, all sixteen condition selectors are swept over the resulting flags, while illegal or non-valid operations are presented so that the hold rule is checked on the same flags.

// File: rtl/alu_ccu_pkg.sv
package alu_ccu_pkg;
  localparam int unsigned FUNC_W = 4;

  localparam logic [FUNC_W-1:0] OP_ADD = 4'd0;
  localparam logic [FUNC_W-1:0] OP_SUB = 4'd1;
  localparam logic [FUNC_W-1:0] OP_AND = 4'd2;
  localparam logic [FUNC_W-1:0] OP_XOR = 4'd3;
  localparam int unsigned NUM_OPS = 4;

  localparam logic [FUNC_W-1:0] CC_ALWAYS = 4'd0;
  localparam logic [FUNC_W-1:0] CC_LE     = 4'd1;
  localparam logic [FUNC_W-1:0] CC_LT     = 4'd2;
  localparam logic [FUNC_W-1:0] CC_EQ     = 4'd3;
  localparam logic [FUNC_W-1:0] CC_NE     = 4'd4;
  localparam logic [FUNC_W-1:0] CC_GE     = 4'd5;
  localparam logic [FUNC_W-1:0] CC_GT     = 4'd6;
  localparam int unsigned NUM_CONDS = 7;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/alu_ccu_datapath.sv
module alu_ccu_datapath
  import alu_ccu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W-1:0]      result,
  output logic              legal,
  output flags_t            next_flags
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic         add_ovf;
  logic         sub_ovf;

  assign sum  = a + b;
  assign diff = b - a;
  assign add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);
  assign legal = (func < FUNC_W'(NUM_OPS));

  always_comb begin
    result        = '0;
    next_flags.of = 1'b0;
    case (func)
      OP_ADD: begin result = sum;  next_flags.of = add_ovf; end
      OP_SUB: begin result = diff; next_flags.of = sub_ovf; end
      OP_AND: result = a & b;
      OP_XOR: result = a ^ b;
      default: result = '0;
    endcase
    next_flags.zf = (result == '0);
    next_flags.sf = result[MSB];
  end
endmodule

// File: rtl/alu_ccu_flags.sv
module alu_ccu_flags
  import alu_ccu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [FUNC_W-1:0] func,
  input  logic [W-1:0]      result,
  input  flags_t            next_flags,
  output flags_t            flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags <= FLAGS_RESET;
    else if (commit) flags <= next_flags;
  end

  a_r4_zf_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (flags.zf == ($past(result) == '0)));
  a_r4_sf_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (flags.sf == $past(result[W-1])));
  a_r4_logic_of_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (func == OP_AND || func == OP_XOR)) |=> !flags.of);
  a_r5_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(flags));
endmodule

// File: rtl/alu_ccu_cond.sv
module alu_ccu_cond
  import alu_ccu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FUNC_W-1:0] cond_func,
  input  flags_t            flags,
  output logic              cond_true
);
  localparam int unsigned TABLE_N = 1 << FUNC_W;

  logic               lt;
  logic [TABLE_N-1:0] table_hit;

  assign lt = flags.sf ^ flags.of;

  always_comb begin
    table_hit        = '0;
    table_hit[CC_ALWAYS] = 1'b1;
    table_hit[CC_LE]     = lt | flags.zf;
    table_hit[CC_LT]     = lt;
    table_hit[CC_EQ]     = flags.zf;
    table_hit[CC_NE]     = ~flags.zf;
    table_hit[CC_GE]     = ~lt;
    table_hit[CC_GT]     = ~lt & ~flags.zf;
  end

  assign cond_true = table_hit[cond_func];

  a_r7_always_true: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_func == CC_ALWAYS) |-> cond_true);
  a_r7_le_is_lt_or_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_func == CC_LE) |-> (cond_true == (table_hit[CC_LT] | table_hit[CC_EQ])));
  a_r7_ge_gt_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_func == CC_GT && cond_true) |-> table_hit[CC_GE] && table_hit[CC_NE]);
  a_r8_unknown_false: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_func >= FUNC_W'(NUM_CONDS)) |-> !cond_true);
endmodule

// File: rtl/alu_ccu.sv
module alu_ccu
  import alu_ccu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [FUNC_W-1:0] op_func,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  output logic [W-1:0]      op_result,
  input  logic [FUNC_W-1:0] cond_func,
  output logic              cond_true,
  output logic              flag_zf,
  output logic              flag_sf,
  output logic              flag_of
);
  logic   legal;
  logic   commit;
  flags_t next_flags;
  flags_t flags;

  alu_ccu_datapath #(.W(W)) u_dp (
    .func       (op_func),
    .a          (op_a),
    .b          (op_b),
    .result     (op_result),
    .legal      (legal),
    .next_flags (next_flags)
  );

  assign commit = op_valid & legal;

  alu_ccu_flags #(.W(W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .func       (op_func),
    .result     (op_result),
    .next_flags (next_flags),
    .flags      (flags)
  );

  alu_ccu_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_func (cond_func),
    .flags     (flags),
    .cond_true (cond_true)
  );

  assign flag_zf = flags.zf;
  assign flag_sf = flags.sf;
  assign flag_of = flags.of;

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_func >= FUNC_W'(NUM_OPS)) |-> (op_result == '0));
endmodule

// File: tb/sim_alu_ccu.sv
`timescale 1ns/10ps
module sim_alu_ccu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_func = 4'd0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] op_result;
  logic [3:0]  cond_func = 4'd0;
  logic        cond_true;
  logic        flag_zf, flag_sf, flag_of;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  bit          done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic        m_zf, m_sf, m_of;

  always #4 clk = ~clk;

  alu_ccu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_func(op_func),
    .op_a(op_a), .op_b(op_b), .op_result(op_result), .cond_func(cond_func),
    .cond_true(cond_true), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h8000_0001;
      6: return 32'h5555_5555;
      default: return 32'hAAAA_AAAA;
    endcase
  endfunction

  function automatic logic [31:0] exp_res(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      4'd0: return a + b;
      4'd1: return b - a;
      4'd2: return a & b;
      4'd3: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_of(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    logic signed [32:0] wide;
    if (f == 4'd0) wide = $signed({a[31], a}) + $signed({b[31], b});
    else if (f == 4'd1) wide = $signed({b[31], b}) - $signed({a[31], a});
    else return 1'b0;
    return wide[32] != wide[31];
  endfunction

  function automatic logic exp_cond(input logic [3:0] c);
    logic l;
    l = m_sf ^ m_of;
    case (c)
      4'd0: return 1'b1;
      4'd1: return l | m_zf;
      4'd2: return l;
      4'd3: return m_zf;
      4'd4: return !m_zf;
      4'd5: return !l;
      4'd6: return !l && !m_zf;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_flags(input string req);
    chk(req, {29'd0, flag_zf, flag_sf, flag_of}, {29'd0, m_zf, m_sf, m_of});
  endtask

  // Sweep all condition selectors; meanwhile present non-committing operations (R5).
  task automatic sweep_conds();
    for (int c = 0; c < 16; c++) begin
      seed = nxt(seed);
      cond_func = 4'(c);
      if (seed[31]) begin op_valid = 1'b0; op_func = seed[3:0]; end
      else begin op_valid = 1'b1; op_func = 4'd4 + 4'(seed[5:2] % 12); end
      op_a = nxt(seed); op_b = seed;
      #1;
      chk((c < 7) ? "R7 cond table" : "R8 unknown cond", {31'd0, cond_true}, {31'd0, exp_cond(4'(c))});
      @(negedge clk);
      check_flags("R5 flags hold");
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    op_valid = v; op_func = f; op_a = a; op_b = b;
    r = exp_res(f, a, b);
    #1;
    case (f)
      4'd0: chk("R1 add", op_result, r);
      4'd1: chk("R2 sub", op_result, r);
      4'd2, 4'd3: chk("R3 logic", op_result, r);
      default: chk("R9 illegal result", op_result, r);
    endcase
    @(posedge clk);
    if (v && f < 4'd4) begin
      m_zf = (r == 32'd0); m_sf = r[31]; m_of = exp_of(f, a, b);
    end
    @(negedge clk);
    op_valid = 1'b0;
    check_flags((v && f < 4'd4) ? "R4 flags update" : "R5 flags hold");
    sweep_conds();
  endtask

  initial begin
    m_zf = 1'b1; m_sf = 1'b0; m_of = 1'b0;
    repeat (3) @(negedge clk);
    check_flags("R6 reset flags");
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("R6 flags after reset");
    sweep_conds();
    for (int f = 0; f < 16; f++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          seed = nxt(seed);
          apply((seed[30:28] != 3'd0), 4'(f), corner(i), corner(j));
        end
      for (int k = 0; k < 24; k++) begin
        logic [31:0] x;
        seed = nxt(seed); x = seed;
        seed = nxt(seed);
        apply(seed[0] | seed[1], 4'(f), x, seed);
      end
    end
    // Explicit boundary: overflowing add giving SF=1, OF=1 (less must be false).
    apply(1'b1, 4'd0, 32'h7FFF_FFFF, 32'h0000_0001);
    chk("R4 add overflow", {29'd0, flag_zf, flag_sf, flag_of}, 32'd3);
    // Overflow to zero: 0x80000000 + 0x80000000.
    apply(1'b1, 4'd0, 32'h8000_0000, 32'h8000_0000);
    chk("R4 zero by overflow", {29'd0, flag_zf, flag_sf, flag_of}, 32'd5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule